// File: doc/BRIEF.md
# Shared DRAM Address Sequencer

This block lets a CPU and a display fetch engine share a 128 KB DRAM built from two 64 KB banks. It produces the row strobe, one column strobe per bank, the write enable, a select line that steers external CPU-address multiplexers between the row and column halves of the CPU address, and a display-owns-bus flag. While that flag is high, the external multiplexers are disabled and the block drives the 8-bit multiplexed DRAM address itself.

Each display fetch opens one row and reads four consecutive bytes in page mode. The two lowest address bits step through the column address while the row stays open. The fetch address comes from an internal long-word counter with a screen-select bit placed above it.

The mapping from linear address bits to row and column bits is scrambled. Row bits are taken from the low and middle address bits, so the sequential screen reads visit every DRAM row within 1024 fetches. This refreshes the DRAM without separate refresh cycles. When a display fetch and a CPU access want the bus in the same idle cycle, the fetch goes first and the CPU acknowledge is delayed.

Top module: `dram_share_seq`

## Requirements
- R1: After reset, `ras_n`=1, `cas_n`=2'b11, `we_n`=1, `vda`=0, `cpu_ack_n`=1, `disp_byte_stb`=0, and the first display fetch uses long-word index 0.
- R2: The display fetch address is {scr_sel, word[12:0], col[1:0]} (bit 15 down to bit 0). In the cycle before `ras_n` falls and while it falls, `dram_addr` bits 7..0 carry address bits 11,10,9,8,7,4,3,2.
- R3: In the column phase, `dram_addr` bits 7..0 carry address bits 15,14,13,12,6,5,1,0. Display fetches strobe only `cas_n[0]`. A CPU access strobes `cas_n[A16]`. Both bits of `cas_n` are never low together.
- R4: A fetch lowers `ras_n` once and then gives four column strobes, each preceded by one cycle with `cas_n` high. The column bits 1..0 run 00, 01, 10, 11, and `disp_byte_stb` marks each strobe, with `disp_byte_idx` equal to the column bits. A column strobe is only ever low while `ras_n` is low.
- R5: `scr_sel` appears as address bit 15 of the fetch address, on `dram_addr[7]` in the column phase.
- R6: `we_n` is low only during the column strobe of a CPU write (`cpu_wr_n`=0). It stays high during CPU reads and during all display fetches.
- R7: `vda` is high for the whole of a display fetch: set-up, row, column and precharge cycles (12 cycles from the request edge to the return to idle). It is low during CPU accesses.
- R8: `row_sel_n` is 0 during the row phase of a CPU RAM access (`cpu_a17`=1) and 1 from its column phase through precharge. It is 1 when idle with `cpu_ds_n`=0 and `cpu_a17`=0, and 0 otherwise in idle.
- R9: If a display request and a CPU RAM access are both waiting in the same idle cycle, the fetch runs first and `cpu_ack_n` stays high until the CPU access reaches its column strobe.
- R10: For a CPU RAM access, `cpu_ack_n` falls together with the column strobe, three cycles after the access starts, and stays low until `cpu_ds_n` returns high. Accesses with `cpu_a17`=0 never get an acknowledge.
- R11: The long-word index rises by one per completed fetch and wraps to 0 after 8192 fetches. 1024 consecutive fetches present all 256 row addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_ds_n | input | 1 | CPU data strobe, low while an access is in progress |
| cpu_wr_n | input | 1 | CPU direction, 0 = write, 1 = read |
| cpu_a17 | input | 1 | CPU address bit 17, 1 selects DRAM |
| cpu_a16 | input | 1 | CPU address bit 16, selects the DRAM bank |
| scr_sel | input | 1 | Screen select, becomes bit 15 of the fetch address |
| disp_req | input | 1 | One-cycle request for a long-word display fetch |
| dram_addr | output | 8 | Multiplexed DRAM address, driven while `vda` is high |
| ras_n | output | 1 | DRAM row strobe |
| cas_n | output | 2 | Column strobes, bit 0 low bank, bit 1 high bank |
| we_n | output | 1 | DRAM write enable |
| row_sel_n | output | 1 | External CPU-address mux select, 0 = row half |
| vda | output | 1 | Display owns the DRAM address bus |
| cpu_ack_n | output | 1 | CPU transfer acknowledge, active low |
| disp_byte_stb | output | 1 | A display byte is being strobed out of the DRAM |
| disp_byte_idx | output | 2 | Byte position within the long word for that strobe |

## Verification
The assertions check, on every cycle, the properties that hold regardless of the scenario: at most one column strobe is low, a column strobe is never low without the row strobe, the display never writes, and the display never overlaps a CPU acknowledge. They also check that an acknowledge holds while the strobe stays low, that I/O-area strobes are never acknowledged, and that the fetch counter steps by one. The scrambled row and column bit placement, the column order within a page, and the screen-select position can only be shown by the bench, which compares `dram_addr` against its own bit mapping. The same applies to the priority ordering when both masters arrive together, the exact acknowledge cycle, full row coverage over 1024 fetches, and the wrap of the fetch counter.

// File: rtl/dram_share_pkg.sv
package dram_share_pkg;

  localparam int ADDR_W = 16;
  localparam int MUX_W  = 8;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DSET,
    S_DRAS,
    S_DCOLA,
    S_DCOLB,
    S_DPRE,
    S_CROW,
    S_CRAS,
    S_CCOL,
    S_CCAS,
    S_CPRE
  } seq_state_t;

  // Row half: bits chosen so that the low long-word index bits land in the row.
  function automatic logic [MUX_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    logic [MUX_W-1:0] r;
    r[0] = a[2];
    r[1] = a[3];
    r[2] = a[4];
    r[3] = a[7];
    r[4] = a[8];
    r[5] = a[9];
    r[6] = a[10];
    r[7] = a[11];
    return r;
  endfunction

  // Column half: byte-in-word bits plus the slowly changing high bits.
  function automatic logic [MUX_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    logic [MUX_W-1:0] c;
    c[0] = a[0];
    c[1] = a[1];
    c[2] = a[5];
    c[3] = a[6];
    c[4] = a[12];
    c[5] = a[13];
    c[6] = a[14];
    c[7] = a[15];
    return c;
  endfunction

endpackage

// File: rtl/dram_fetch_ctr.sv
module dram_fetch_ctr #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [CNT_W-1:0] word_idx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word_idx <= '0;
    else if (adv) word_idx <= word_idx + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (word_idx == $past(word_idx) + 1'b1)); // R11

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(word_idx)); // R11

endmodule

// File: rtl/dram_addr_map.sv
module dram_addr_map
  import dram_share_pkg::*;
(
  input  logic              drive,
  input  logic              col_phase,
  input  logic [ADDR_W-1:0] lin_addr,
  output logic [MUX_W-1:0]  mux_addr
);

  always_comb begin
    if (!drive)         mux_addr = '0;
    else if (col_phase) mux_addr = col_of(lin_addr);
    else                mux_addr = row_of(lin_addr);
  end

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_share_pkg::*;
#(
  parameter int DISP_BANK = 0,
  parameter int NBANK     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_ds_n,
  input  logic             cpu_wr_n,
  input  logic             cpu_a17,
  input  logic             cpu_a16,
  input  logic             disp_req,
  output logic             ras_n,
  output logic [NBANK-1:0] cas_n,
  output logic             we_n,
  output logic             row_sel_n,
  output logic             vda,
  output logic             cpu_ack_n,
  output logic             col_phase,
  output logic [1:0]       col_idx,
  output logic             fetch_done,
  output logic             disp_byte_stb
);

  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  seq_state_t  state, state_d;
  logic        pend, pend_d;
  logic [1:0]  col_q, col_d;
  logic [BANK_W-1:0] bank_q, bank_d;

  logic cpu_ram_req, cpu_io_req, disp_want;
  assign cpu_ram_req = !cpu_ds_n && cpu_a17;
  assign cpu_io_req  = !cpu_ds_n && !cpu_a17;
  assign disp_want   = disp_req || pend;

  always_comb begin
    state_d = state;
    case (state)
      S_IDLE:  if (disp_want)        state_d = S_DSET;
               else if (cpu_ram_req) state_d = S_CROW;
      S_DSET:  state_d = S_DRAS;
      S_DRAS:  state_d = S_DCOLA;
      S_DCOLA: state_d = S_DCOLB;
      S_DCOLB: state_d = (col_q == 2'd3) ? S_DPRE : S_DCOLA;
      S_DPRE:  state_d = S_IDLE;
      S_CROW:  state_d = S_CRAS;
      S_CRAS:  state_d = S_CCOL;
      S_CCOL:  state_d = S_CCAS;
      S_CCAS:  if (cpu_ds_n) state_d = S_CPRE;
      S_CPRE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    pend_d = pend || disp_req;
    if (state == S_IDLE) pend_d = 1'b0;
    col_d = col_q;
    if (state == S_DRAS)  col_d = 2'd0;
    if (state == S_DCOLB) col_d = col_q + 2'd1;
    bank_d = bank_q;
    if (state == S_IDLE && state_d == S_CROW) bank_d = BANK_W'(cpu_a16);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pend   <= 1'b0;
      col_q  <= 2'd0;
      bank_q <= '0;
    end else begin
      state  <= state_d;
      pend   <= pend_d;
      col_q  <= col_d;
      bank_q <= bank_d;
    end
  end

  logic disp_state, cpu_state, ras_low;
  assign disp_state = (state inside {S_DSET, S_DRAS, S_DCOLA, S_DCOLB, S_DPRE});
  assign cpu_state  = (state inside {S_CROW, S_CRAS, S_CCOL, S_CCAS, S_CPRE});
  assign ras_low    = (state inside {S_DRAS, S_DCOLA, S_DCOLB, S_CRAS, S_CCOL, S_CCAS});

  always_comb begin
    ras_n         = !ras_low;
    cas_n         = '1;
    we_n          = 1'b1;
    vda           = disp_state;
    cpu_ack_n     = 1'b1;
    col_phase     = (state == S_DCOLA) || (state == S_DCOLB);
    col_idx       = col_q;
    fetch_done    = (state == S_DPRE);
    disp_byte_stb = (state == S_DCOLB);
    if (state == S_DCOLB) cas_n[DISP_BANK] = 1'b0;
    if (state == S_CCAS) begin
      cas_n[bank_q] = 1'b0;
      we_n          = cpu_wr_n;
      cpu_ack_n     = 1'b0;
    end
    if (cpu_state)         row_sel_n = !(state == S_CROW || state == S_CRAS);
    else if (disp_state)   row_sel_n = 1'b0;
    else                   row_sel_n = cpu_io_req;
  end

  AST_CAS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cas_n)); // R3

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != '1) |-> !ras_n); // R4

  AST_DISP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    vda |-> we_n); // R6

  AST_DISP_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vda |-> cpu_ack_n); // R9

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ack_n && !cpu_ds_n) |=> !cpu_ack_n); // R10

  AST_IO_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_io_req && !cpu_state) |-> cpu_ack_n); // R10

endmodule

// File: rtl/dram_share_seq.sv
module dram_share_seq
  import dram_share_pkg::*;
#(
  parameter int DISP_BANK = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_ds_n,
  input  logic       cpu_wr_n,
  input  logic       cpu_a17,
  input  logic       cpu_a16,
  input  logic       scr_sel,
  input  logic       disp_req,
  output logic [7:0] dram_addr,
  output logic       ras_n,
  output logic [1:0] cas_n,
  output logic       we_n,
  output logic       row_sel_n,
  output logic       vda,
  output logic       cpu_ack_n,
  output logic       disp_byte_stb,
  output logic [1:0] disp_byte_idx
);

  localparam int CNT_W = ADDR_W - 3;  // long words below the screen-select bit
  localparam int NBANK = 2;

  logic             col_phase, fetch_done;
  logic [1:0]       col_idx;
  logic [CNT_W-1:0] word_idx;
  logic [ADDR_W-1:0] fetch_addr;

  assign fetch_addr    = {scr_sel, word_idx, col_idx};
  assign disp_byte_idx = col_idx;

  dram_seq_fsm #(.DISP_BANK(DISP_BANK), .NBANK(NBANK)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_ds_n     (cpu_ds_n),
    .cpu_wr_n     (cpu_wr_n),
    .cpu_a17      (cpu_a17),
    .cpu_a16      (cpu_a16),
    .disp_req     (disp_req),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .row_sel_n    (row_sel_n),
    .vda          (vda),
    .cpu_ack_n    (cpu_ack_n),
    .col_phase    (col_phase),
    .col_idx      (col_idx),
    .fetch_done   (fetch_done),
    .disp_byte_stb(disp_byte_stb)
  );

  dram_fetch_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (fetch_done),
    .word_idx(word_idx)
  );

  dram_addr_map u_map (
    .drive    (vda),
    .col_phase(col_phase),
    .lin_addr (fetch_addr),
    .mux_addr (dram_addr)
  );

  AST_ROW_HELD_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (vda && !ras_n && !$past(ras_n) && $past(vda)) |-> $stable(word_idx)); // R4

endmodule

// File: tb/sim_dram_share_seq.sv
module sim_dram_share_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_ds_n = 1'b1, cpu_wr_n = 1'b1, cpu_a17 = 1'b0, cpu_a16 = 1'b0;
  logic scr_sel = 1'b0, disp_req = 1'b0;
  logic [7:0] dram_addr;
  logic ras_n, we_n, row_sel_n, vda, cpu_ack_n, disp_byte_stb;
  logic [1:0] cas_n, disp_byte_idx;

  always #4 clk = ~clk;  // 125 MHz

  dram_share_seq u0 (
    .clk(clk), .rst_n(rst_n), .cpu_ds_n(cpu_ds_n), .cpu_wr_n(cpu_wr_n),
    .cpu_a17(cpu_a17), .cpu_a16(cpu_a16), .scr_sel(scr_sel), .disp_req(disp_req),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .row_sel_n(row_sel_n), .vda(vda), .cpu_ack_n(cpu_ack_n),
    .disp_byte_stb(disp_byte_stb), .disp_byte_idx(disp_byte_idx)
  );

  int n_chk = 0, n_fail = 0;
  int w_exp = 0;
  bit done = 1'b0;
  bit seen [256];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bench-side bit placement, written as slices
  function automatic logic [7:0] exp_row(input logic [15:0] a);
    return {a[11:7], a[4:2]};
  endfunction
  function automatic logic [7:0] exp_col(input logic [15:0] a);
    return {a[15:12], a[6:5], a[1:0]};
  endfunction

  task automatic fetch_start(input logic scr);
    @(negedge clk);
    scr_sel  = scr;
    disp_req = 1'b1;
  endtask

  // First sample lands in the set-up cycle; last sample in idle.
  task automatic fetch_body(input bit full, input bit chk_ack);
    logic [15:0] a;
    a = {scr_sel, w_exp[12:0], 2'b00};
    @(negedge clk);
    disp_req = 1'b0;
    if (full) begin
      chk(vda == 1'b1, "R7", "vda in setup", vda, 1);
      chk(ras_n == 1'b1, "R2", "ras before fall", ras_n, 1);
      chk(dram_addr == exp_row(a), "R2", "row addr setup", dram_addr, exp_row(a));
    end
    if (chk_ack) chk(cpu_ack_n == 1'b1, "R9", "ack held in setup", cpu_ack_n, 1);
    @(negedge clk);
    seen[dram_addr] = 1'b1;
    if (full) begin
      chk(ras_n == 1'b0, "R4", "ras low", ras_n, 0);
      chk(dram_addr == exp_row(a), "R2", "row addr at ras", dram_addr, exp_row(a));
    end
    for (int k = 0; k < 4; k++) begin
      logic [15:0] ak;
      ak = a | 16'(k);
      @(negedge clk);
      if (full) begin
        chk(cas_n == 2'b11, "R4", "cas high gap", cas_n, 3);
        chk(ras_n == 1'b0, "R4", "row stays open", ras_n, 0);
        chk(dram_addr == exp_col(ak), "R3", "col addr", dram_addr, exp_col(ak));
        chk(dram_addr[7] == scr_sel, "R5", "screen bit", dram_addr[7], scr_sel);
      end
      if (chk_ack) chk(cpu_ack_n == 1'b1, "R9", "ack held in col", cpu_ack_n, 1);
      @(negedge clk);
      if (full) begin
        chk(cas_n == 2'b10, "R3", "display uses low bank", cas_n, 2);
        chk(disp_byte_stb == 1'b1 && disp_byte_idx == 2'(k), "R4", "byte index",
            disp_byte_idx, k);
        chk(we_n == 1'b1, "R6", "display reads", we_n, 1);
      end
      if (chk_ack) chk(cpu_ack_n == 1'b1, "R9", "ack held at strobe", cpu_ack_n, 1);
    end
    @(negedge clk);
    if (full) chk(ras_n == 1'b1 && vda == 1'b1, "R7", "precharge owned", {ras_n, vda}, 3);
    @(negedge clk);
    if (full) chk(vda == 1'b0, "R7", "vda drops in idle", vda, 0);
    if (chk_ack) chk(cpu_ack_n == 1'b1, "R9", "ack held in idle", cpu_ack_n, 1);
    w_exp++;
  endtask

  task automatic fetch(input logic scr, input bit full);
    fetch_start(scr);
    fetch_body(full, 1'b0);
  endtask

  task automatic cpu_start(input logic a16, input logic wr_n);
    @(negedge clk);
    cpu_a17 = 1'b1; cpu_a16 = a16; cpu_wr_n = wr_n; cpu_ds_n = 1'b0;
  endtask

  // First sample lands in the row set-up cycle.
  task automatic cpu_body(input int hold);
    logic [1:0] cas_exp;
    cas_exp = cpu_a16 ? 2'b01 : 2'b10;
    @(negedge clk);
    chk(row_sel_n == 1'b0 && ras_n == 1'b1, "R8", "row half before ras", {row_sel_n, ras_n}, 1);
    chk(vda == 1'b0, "R7", "vda low for cpu", vda, 0);
    @(negedge clk);
    chk(row_sel_n == 1'b0 && ras_n == 1'b0, "R8", "row half at ras", {row_sel_n, ras_n}, 0);
    chk(cpu_ack_n == 1'b1, "R10", "no early ack", cpu_ack_n, 1);
    @(negedge clk);
    chk(row_sel_n == 1'b1 && cas_n == 2'b11, "R8", "column half", {row_sel_n, cas_n}, 7);
    @(negedge clk);
    chk(cas_n == cas_exp, "R3", "cpu bank strobe", cas_n, cas_exp);
    chk(cpu_ack_n == 1'b0, "R10", "ack with strobe", cpu_ack_n, 0);
    chk(we_n == cpu_wr_n, "R6", "we follows direction", we_n, cpu_wr_n);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(cpu_ack_n == 1'b0, "R10", "ack held", cpu_ack_n, 0);
    end
    cpu_ds_n = 1'b1;
    @(negedge clk);
    chk(cpu_ack_n == 1'b1 && ras_n == 1'b1 && cas_n == 2'b11, "R10", "release",
        {cpu_ack_n, ras_n, cas_n}, 15);
    chk(we_n == 1'b1, "R6", "we high after", we_n, 1);
    @(negedge clk);
    chk(row_sel_n == 1'b0, "R8", "idle row half", row_sel_n, 0);
    cpu_a17 = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(ras_n == 1'b1 && cas_n == 2'b11 && we_n == 1'b1, "R1", "strobes idle",
        {ras_n, cas_n, we_n}, 15);
    chk(vda == 1'b0 && cpu_ack_n == 1'b1 && disp_byte_stb == 1'b0, "R1", "flags idle",
        {vda, cpu_ack_n, disp_byte_stb}, 2);
    fetch(1'b0, 1'b1);  // word 0 checked inside: R1
  endtask

  task automatic t_io;
    @(negedge clk);
    cpu_a17 = 1'b0; cpu_a16 = 1'b1; cpu_wr_n = 1'b0; cpu_ds_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(row_sel_n == 1'b1, "R8", "io column half", row_sel_n, 1);
      chk(cpu_ack_n == 1'b1 && ras_n == 1'b1, "R10", "io no ack", {cpu_ack_n, ras_n}, 3);
    end
    cpu_ds_n = 1'b1;
    @(negedge clk);
    chk(row_sel_n == 1'b0, "R8", "idle after io", row_sel_n, 0);
  endtask

  task automatic t_contend;
    @(negedge clk);
    scr_sel = 1'b0; disp_req = 1'b1;
    cpu_a17 = 1'b1; cpu_a16 = 1'b0; cpu_wr_n = 1'b1; cpu_ds_n = 1'b0;
    fetch_body(1'b1, 1'b1);
    cpu_body(1);
  endtask

  task automatic t_refresh_wrap;
    foreach (seen[i]) seen[i] = 1'b0;
    for (int f = 0; f < 1024; f++) fetch(1'b0, 1'b0);
    begin
      int miss;
      miss = 0;
      foreach (seen[i]) if (!seen[i]) miss++;
      chk(miss == 0, "R11", "rows missed over 1024 fetches", miss, 0);
    end
    while (w_exp < 8192) fetch(1'b1, 1'b0);
    fetch(1'b1, 1'b1);  // index wrapped to 0: R11
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    fetch(1'b1, 1'b1);
    fetch(1'b0, 1'b1);
    cpu_start(1'b0, 1'b1); cpu_body(2);
    cpu_start(1'b1, 1'b0); cpu_body(0);
    t_io;
    t_contend;
    t_refresh_wrap;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule